// File: doc/BRIEF.md
# Privilege-Based Cache Hit Detector

This block holds the tag and access rights of every line of a small direct-mapped L1 data cache shared by several hardware threads. It keeps no coherence state. Each line carries a tag and two rights bits, one that allows reads and one that allows writes. Hit or miss is decided only from the tag comparison and these two bits. Only the cache controller changes them, through a dedicated update port.

A lookup presents a thread number, a byte address and an operation. The operation is a load, a store or a flush. The line is read from the store in the cycle the lookup is sampled. The comparison is made in the following cycle, and its outcome appears on the result outputs:
- hit or miss;
- whether a valid line of another tag stands in the way, which is an eviction;
- whether a flush found the line present.

A miss also raises a sleep request for the thread that made the lookup. The instruction issue logic uses it to stop issuing from that thread until the controller has resolved the miss.

Top module: `hd_privilege_hit_detector`

## Requirements
- R1: After reset, every line has both rights bits cleared and `res_valid` and `sleep_req` are low. The first load or store to any line therefore misses and flags no eviction.
- R2: A lookup is sampled on the rising edge where `lk_valid` is high, and its result is shown in the cycle that follows that edge. `res_valid` is high exactly in that cycle and `res_thread` repeats `lk_thread`. With no lookup sampled, `res_valid` is low.
- R3: A load (`lk_store`=0, `lk_flush`=0) hits when the stored tag equals the lookup tag and the read right is set. Otherwise it misses.
- R4: A store (`lk_store`=1, `lk_flush`=0) hits when the stored tag equals the lookup tag and the write right is set. Otherwise it misses.
- R5: A store whose tag matches a line that has the read right but lacks the write right is reported as a miss, with `res_evict` low.
- R6: `res_evict` is high only for a load or store miss that finds a line with at least one rights bit set and a stored tag different from the lookup tag. A line with both bits clear never causes an eviction.
- R7: On a miss, `sleep_req` has exactly the bit of the requesting thread set, with bit n standing for thread n. Without a miss it is all zero.
- R8: With `lk_flush`=1, `lk_store` has no effect. The result then has `res_hit`, `res_miss`, `res_evict` and `sleep_req` all low. `res_flush` is high exactly when the stored tag matches and at least one rights bit is set.
- R9: Lookups never change a line's tag or rights: repeating a lookup with no update in between gives the same result.
- R10: When an update and a lookup of the same line are sampled on the same edge, the lookup reports the line's previous contents. The next lookup reports the updated contents.
- R11: The address is split, from the least significant bit, into `OFFSET_W` offset bits, `INDEX_W` line-index bits and a tag made of the rest. The offset bits do not affect the result.
- R12: An update sampled with `upd_valid` high writes `upd_tag`, `upd_can_read` and `upd_can_write` into line `upd_index`. Nothing else changes a line's rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_thread | input | TID_W | Requesting thread number |
| lk_addr | input | ADDR_W | Byte address of the lookup |
| lk_store | input | 1 | 1 for a store, 0 for a load |
| lk_flush | input | 1 | Lookup is a flush probe; overrides lk_store |
| upd_valid | input | 1 | Controller writes a line |
| upd_index | input | INDEX_W | Line being written |
| upd_tag | input | TAG_W | New tag for the line |
| upd_can_read | input | 1 | New read right |
| upd_can_write | input | 1 | New write right |
| res_valid | output | 1 | Result of the previous cycle's lookup is shown |
| res_thread | output | TID_W | Thread of the shown result |
| res_hit | output | 1 | Load or store hit |
| res_miss | output | 1 | Load or store miss |
| res_evict | output | 1 | Miss displaces a valid line of another tag |
| res_flush | output | 1 | Flush found the line present |
| sleep_req | output | THREADS | One-hot sleep request for the missing thread |

## Verification
The hardest case to reach from the ports is a lookup whose line has a particular combination of rights and tag relation. Examples are a matching tag with only the read right, or a foreign tag on a line with only the write right. The bench reaches every such case by programming each line through the update port with all four rights combinations. It then probes each line with a load, a store and a flush, once with the matching tag and once with a foreign tag. Each probe is issued twice so that it can be seen that lookups leave the line untouched. A separate sequence places an update and a lookup of the same line on the same edge to expose the read-before-write ordering.

// File: rtl/hd_pkg.sv
package hd_pkg;
   typedef struct packed {
      logic can_rd;
      logic can_wr;
   } rights_t;

   function automatic logic rights_present(rights_t r);
      return r.can_rd | r.can_wr;
   endfunction
endpackage

// File: rtl/hd_line_store.sv
module hd_line_store
   import hd_pkg::*;
#(
   parameter int INDEX_W    = 3,
   parameter int TAG_W      = 7,
   parameter bit RESET_TAGS = 1'b1,
   localparam int LINES     = 1 << INDEX_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_en,
   input  logic [INDEX_W-1:0] rd_index,
   output logic [TAG_W-1:0]   rd_tag_q,
   output rights_t            rd_rights_q,
   input  logic               wr_en,
   input  logic [INDEX_W-1:0] wr_index,
   input  logic [TAG_W-1:0]   wr_tag,
   input  rights_t            wr_rights
);
   logic    [LINES-1:0][TAG_W-1:0] tag_q;
   rights_t [LINES-1:0]            rights_q;

   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic sel;
      assign sel = wr_en && (wr_index == INDEX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rights_q[g] <= '0;
         else if (sel) rights_q[g] <= wr_rights;
      end

      if (RESET_TAGS) begin : g_tag_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tag_q[g] <= '0;
            else if (sel) tag_q[g] <= wr_tag;
         end
      end else begin : g_tag_norst
         always_ff @(posedge clk) begin
            if (sel) tag_q[g] <= wr_tag;
         end
      end
   end

   // Registered read of the contents before any same-edge write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_tag_q    <= '0;
         rd_rights_q <= '0;
      end else if (rd_en) begin
         rd_tag_q    <= tag_q[rd_index];
         rd_rights_q <= rights_q[rd_index];
      end
   end

   AST_RIGHTS_ONLY_BY_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rights_q)); // R12
   AST_READ_TRACKS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en) |=> (rd_rights_q == rights_q[$past(rd_index)])); // R9
endmodule

// File: rtl/hd_compare.sv
module hd_compare
   import hd_pkg::*;
#(
   parameter int TAG_W = 7
) (
   input  logic             req_valid,
   input  logic             req_store,
   input  logic             req_flush,
   input  logic [TAG_W-1:0] req_tag,
   input  logic [TAG_W-1:0] line_tag,
   input  rights_t          line_rights,
   output logic             hit,
   output logic             miss,
   output logic             evict,
   output logic             flush_found
);
   logic tag_eq;
   logic present;
   logic need;

   always_comb begin
      tag_eq  = (line_tag == req_tag);
      present = rights_present(line_rights);
      need    = req_store ? line_rights.can_wr : line_rights.can_rd;
      hit         = 1'b0;
      miss        = 1'b0;
      evict       = 1'b0;
      flush_found = 1'b0;
      if (req_valid) begin
         if (req_flush) begin
            flush_found = tag_eq && present;
         end else begin
            hit   = tag_eq && need;
            miss  = !(tag_eq && need);
            evict = !(tag_eq && need) && present && !tag_eq;
         end
      end
   end

   AST_HIT_MISS_EXCL: assert final (!(hit && miss)); // R3
   AST_FLUSH_QUIET: assert final (!(flush_found && (hit || miss || evict))); // R8
endmodule

// File: rtl/hd_sleep_decode.sv
module hd_sleep_decode #(
   parameter int THREADS = 4,
   localparam int TID_W  = $clog2(THREADS)
) (
   input  logic               en,
   input  logic [TID_W-1:0]   thread,
   output logic [THREADS-1:0] sleep
);
   for (genvar g = 0; g < THREADS; g++) begin : g_thr
      assign sleep[g] = en && (thread == TID_W'(g));
   end
endmodule

// File: rtl/hd_privilege_hit_detector.sv
module hd_privilege_hit_detector
   import hd_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int INDEX_W    = 3,
   parameter int OFFSET_W   = 2,
   parameter int THREADS    = 4,
   parameter bit RESET_TAGS = 1'b1,
   localparam int TAG_W     = ADDR_W - INDEX_W - OFFSET_W,
   localparam int TID_W     = $clog2(THREADS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_valid,
   input  logic [TID_W-1:0]   lk_thread,
   input  logic [ADDR_W-1:0]  lk_addr,
   input  logic               lk_store,
   input  logic               lk_flush,
   input  logic               upd_valid,
   input  logic [INDEX_W-1:0] upd_index,
   input  logic [TAG_W-1:0]   upd_tag,
   input  logic               upd_can_read,
   input  logic               upd_can_write,
   output logic               res_valid,
   output logic [TID_W-1:0]   res_thread,
   output logic               res_hit,
   output logic               res_miss,
   output logic               res_evict,
   output logic               res_flush,
   output logic [THREADS-1:0] sleep_req
);
   if (TAG_W < 1) begin : g_bad_split
      $error("address too narrow for index and offset");
   end
   if (OFFSET_W < 1 || INDEX_W < 1) begin : g_bad_geom
      $error("index and offset need at least one bit each");
   end
   if (THREADS < 2) begin : g_bad_threads
      $error("at least two threads required");
   end

   logic [INDEX_W-1:0] lk_index;
   logic [TAG_W-1:0]   lk_tag;
   logic               offset_unused;
   assign lk_index      = lk_addr[OFFSET_W +: INDEX_W];
   assign lk_tag        = lk_addr[ADDR_W-1 -: TAG_W];
   assign offset_unused = ^lk_addr[OFFSET_W-1:0];

   logic             req_valid_q;
   logic [TID_W-1:0] req_thread_q;
   logic [TAG_W-1:0] req_tag_q;
   logic             req_store_q;
   logic             req_flush_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_valid_q  <= 1'b0;
         req_thread_q <= '0;
         req_tag_q    <= '0;
         req_store_q  <= 1'b0;
         req_flush_q  <= 1'b0;
      end else begin
         req_valid_q <= lk_valid;
         if (lk_valid) begin
            req_thread_q <= lk_thread;
            req_tag_q    <= lk_tag;
            req_store_q  <= lk_store;
            req_flush_q  <= lk_flush;
         end
      end
   end

   logic [TAG_W-1:0] line_tag;
   rights_t          line_rights;
   rights_t          upd_rights;
   assign upd_rights = '{can_rd: upd_can_read, can_wr: upd_can_write};

   hd_line_store #(
      .INDEX_W   (INDEX_W),
      .TAG_W     (TAG_W),
      .RESET_TAGS(RESET_TAGS)
   ) store_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (lk_valid),
      .rd_index   (lk_index),
      .rd_tag_q   (line_tag),
      .rd_rights_q(line_rights),
      .wr_en      (upd_valid),
      .wr_index   (upd_index),
      .wr_tag     (upd_tag),
      .wr_rights  (upd_rights)
   );

   hd_compare #(.TAG_W(TAG_W)) cmp_i (
      .req_valid  (req_valid_q),
      .req_store  (req_store_q),
      .req_flush  (req_flush_q),
      .req_tag    (req_tag_q),
      .line_tag   (line_tag),
      .line_rights(line_rights),
      .hit        (res_hit),
      .miss       (res_miss),
      .evict      (res_evict),
      .flush_found(res_flush)
   );

   hd_sleep_decode #(.THREADS(THREADS)) sleep_i (
      .en    (res_miss),
      .thread(req_thread_q),
      .sleep (sleep_req)
   );

   assign res_valid  = req_valid_q;
   assign res_thread = req_thread_q;

   AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> res_valid); // R2
   AST_NO_RESULT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !res_valid && !res_hit && !res_miss && !res_flush); // R2
   AST_SLEEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sleep_req)); // R7
   AST_SLEEP_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      res_miss |-> sleep_req[res_thread]); // R7
   AST_SLEEP_NEEDS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_req != '0) |-> res_miss); // R7
   AST_EVICT_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      res_evict |-> res_miss); // R6
   AST_FLUSH_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      res_flush |-> (sleep_req == '0) && !res_hit); // R8
endmodule

// File: tb/hd_privilege_hit_detector_tb_top.sv
`timescale 1ns/1ps
module hd_privilege_hit_detector_tb_top;
   localparam int ADDR_W   = 12;
   localparam int INDEX_W  = 3;
   localparam int OFFSET_W = 2;
   localparam int THREADS  = 4;
   localparam int TAG_W    = ADDR_W - INDEX_W - OFFSET_W;
   localparam int TID_W    = $clog2(THREADS);
   localparam int LINES    = 1 << INDEX_W;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               lk_valid = 1'b0;
   logic [TID_W-1:0]   lk_thread = '0;
   logic [ADDR_W-1:0]  lk_addr = '0;
   logic               lk_store = 1'b0;
   logic               lk_flush = 1'b0;
   logic               upd_valid = 1'b0;
   logic [INDEX_W-1:0] upd_index = '0;
   logic [TAG_W-1:0]   upd_tag = '0;
   logic               upd_can_read = 1'b0;
   logic               upd_can_write = 1'b0;
   logic               res_valid;
   logic [TID_W-1:0]   res_thread;
   logic               res_hit, res_miss, res_evict, res_flush;
   logic [THREADS-1:0] sleep_req;

   int  n_checks = 0;
   int  n_fail   = 0;
   bit  finished = 1'b0;

   always #2.5 clk = ~clk;

   hd_privilege_hit_detector #(
      .ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .OFFSET_W(OFFSET_W), .THREADS(THREADS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_thread(lk_thread), .lk_addr(lk_addr),
      .lk_store(lk_store), .lk_flush(lk_flush),
      .upd_valid(upd_valid), .upd_index(upd_index), .upd_tag(upd_tag),
      .upd_can_read(upd_can_read), .upd_can_write(upd_can_write),
      .res_valid(res_valid), .res_thread(res_thread), .res_hit(res_hit),
      .res_miss(res_miss), .res_evict(res_evict), .res_flush(res_flush),
      .sleep_req(sleep_req)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic update(int idx, int tag, bit rd, bit wr);
      @(negedge clk);
      upd_valid = 1'b1; upd_index = INDEX_W'(idx); upd_tag = TAG_W'(tag);
      upd_can_read = rd; upd_can_write = wr;
      @(negedge clk);
      upd_valid = 1'b0;
   endtask

   function automatic logic [ADDR_W-1:0] mk_addr(int tag, int idx, int off);
      return {TAG_W'(tag), INDEX_W'(idx), OFFSET_W'(off)};
   endfunction

   // Drive a lookup at a falling edge; the result is sampled one falling edge later
   task automatic lookup(int thr, logic [ADDR_W-1:0] a, bit st, bit fl);
      @(negedge clk);
      lk_valid = 1'b1; lk_thread = TID_W'(thr); lk_addr = a;
      lk_store = st; lk_flush = fl;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   task automatic expect_res(string req, int thr, bit h, bit m, bit e, bit f);
      logic [THREADS-1:0] sl;
      sl = m ? (THREADS'(1) << thr) : '0;
      chk(req, "res_valid", 32'(res_valid), 32'd1);
      chk(req, "res_thread", 32'(res_thread), 32'(thr));
      chk(req, "res_hit", 32'(res_hit), 32'(h));
      chk(req, "res_miss", 32'(res_miss), 32'(m));
      chk(req, "res_evict", 32'(res_evict), 32'(e));
      chk(req, "res_flush", 32'(res_flush), 32'(f));
      chk("R7", "sleep_req", 32'(sleep_req), 32'(sl));
   endtask

   initial begin
      #(5.0 * 100000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "res_valid", 32'(res_valid), 32'd0);
      chk("R1", "sleep_req", 32'(sleep_req), 32'd0);
      for (int i = 0; i < LINES; i++) begin
         lookup(i % THREADS, mk_addr(i * 3, i, 0), i[0], 1'b0);
         expect_res("R1", i % THREADS, 1'b0, 1'b1, 1'b0, 1'b0);
      end
      @(negedge clk);
      chk("R2", "res_valid idle", 32'(res_valid), 32'd0);

      // Exhaustive sweep: line x rights x tag relation x operation
      for (int idx = 0; idx < LINES; idx++) begin
         for (int p = 0; p < 4; p++) begin
            for (int mt = 0; mt < 2; mt++) begin
               for (int op = 0; op < 4; op++) begin
                  int  tag, ltag, thr;
                  bit  rd, wr, st, fl, match, present, need, h, m, e, f;
                  tag  = (idx * 13 + p * 5 + 3) % (1 << TAG_W);
                  ltag = mt ? tag : (tag ^ (1 << (TAG_W - 1)));
                  rd = p[1]; wr = p[0];
                  st = op[0]; fl = op[1];
                  thr = (idx + p + op) % THREADS;
                  update(idx, tag, rd, wr);
                  match   = (mt == 1);
                  present = rd | wr;
                  need    = st ? wr : rd;
                  if (fl) begin
                     h = 0; m = 0; e = 0; f = match && present;
                  end else begin
                     h = match && need; m = !h; e = m && present && !match; f = 0;
                  end
                  // R11: offset bits vary with the operation
                  lookup(thr, mk_addr(ltag, idx, op), st, fl);
                  if (fl) expect_res("R8", thr, h, m, e, f);
                  else if (!match) expect_res("R6", thr, h, m, e, f);
                  else if (st && rd && !wr) expect_res("R5", thr, h, m, e, f);
                  else if (st) expect_res("R4", thr, h, m, e, f);
                  else expect_res("R3", thr, h, m, e, f);
                  // R9: repeat, contents untouched by the lookup
                  lookup((thr + 1) % THREADS, mk_addr(ltag, idx, 3 - op), st, fl);
                  expect_res("R9", (thr + 1) % THREADS, h, m, e, f);
               end
            end
         end
      end
      @(negedge clk);
      chk("R2", "res_valid idle", 32'(res_valid), 32'd0);

      // R12: update writes tag and rights; other lines kept
      update(2, 9, 1'b1, 1'b1);
      update(5, 9, 1'b1, 1'b0);
      lookup(1, mk_addr(9, 2, 1), 1'b1, 1'b0);
      expect_res("R12", 1, 1'b1, 1'b0, 1'b0, 1'b0);
      lookup(3, mk_addr(9, 5, 2), 1'b1, 1'b0);
      expect_res("R12", 3, 1'b0, 1'b1, 1'b0, 1'b0);

      // R10: same-edge update and lookup of one line
      @(negedge clk);
      upd_valid = 1'b1; upd_index = 3'd2; upd_tag = 7'd40;
      upd_can_read = 1'b1; upd_can_write = 1'b0;
      lk_valid = 1'b1; lk_thread = 2'd2; lk_addr = mk_addr(9, 2, 0);
      lk_store = 1'b1; lk_flush = 1'b0;
      @(negedge clk);
      upd_valid = 1'b0; lk_valid = 1'b0;
      expect_res("R10", 2, 1'b1, 1'b0, 1'b0, 1'b0);
      lookup(0, mk_addr(9, 2, 0), 1'b1, 1'b0);
      expect_res("R10", 0, 1'b0, 1'b1, 1'b1, 1'b0);
      lookup(0, mk_addr(40, 2, 0), 1'b0, 1'b0);
      expect_res("R10", 0, 1'b1, 1'b0, 1'b0, 1'b0);

      // Back-to-back lookups on consecutive edges
      @(negedge clk);
      lk_valid = 1'b1; lk_thread = 2'd1; lk_addr = mk_addr(40, 2, 0);
      lk_store = 1'b0; lk_flush = 1'b0;
      @(negedge clk);
      expect_res("R2", 1, 1'b1, 1'b0, 1'b0, 1'b0);
      lk_thread = 2'd3; lk_addr = mk_addr(41, 2, 0);
      @(negedge clk);
      lk_valid = 1'b0;
      expect_res("R2", 3, 1'b0, 1'b1, 1'b1, 1'b0);
      @(negedge clk);
      chk("R2", "res_valid idle", 32'(res_valid), 32'd0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule